// File: doc/BRIEF.md
# Quad DAC Code Register Bank

This block keeps the digital codes for four converter channels. Every channel has two stages. An input stage receives words from a serial-interface decoder that sits outside this block. An output stage drives the channel's code toward the analog side. The decoder presents each write in two steps. First a strobe carries an operation, a channel select and a 16-bit word. Later an end-of-write event marks that the transfer completed validly. Only that event lets the write take effect.

Two asynchronous active-low pins control the block. The update pin moves pending input-stage codes into the output stages, either on a falling edge or continuously while it is held low. The clear pin zeroes every code on its falling edge and aborts any write that has been strobed but not yet completed. It also starts a clear condition that blocks update pulses until the next completed write. At reset all codes take zero-scale or midscale, chosen by a select input. Software writes also set per-channel power-down flags, an internal-reference enable and a high-speed interface flag.

Top module: `dac_quad_bank`

## Requirements
- R1: While `rstN` is low, every input and output code is loaded with midscale (MSB set, other bits clear) if `porMid` is 1, or with zero if `porMid` is 0. At the same time `newData`, `pwrDown`, `refEn`, `hsMode` and `clearMode` are cleared.
- R2: A write with `wrOp`=0 takes effect only at `wrDone`. It puts the upper CODE_W bits of `wrWord` into the input stage of the channel given by `chanSel` (0 to 3 select channels A to D; channel i occupies `dacCode[i*CODE_W +: CODE_W]`). If `ldacN` is not held low, the write sets `newData[i]` and leaves that channel's output code unchanged.
- R3: A falling edge on `ldacN` copies the input stage into the output stage for every channel whose `newData` bit is set, then clears those bits. A channel whose `newData` bit is clear keeps its output code.
- R4: While `ldacN` is held low, a completed code write goes straight to that channel's output code and leaves `newData` clear.
- R5: A falling edge on `clrN` zeroes all input and output codes, clears `newData` and sets `clearMode`.
- R6: While `clrN` is low, or while `clearMode` is set, update edges are ignored. The next completed write of any operation clears `clearMode`.
- R7: A `clrN` falling edge that arrives between a write's strobe and its `wrDone` discards that write, so nothing changes at `wrDone`. The edge also clears `hsMode`.
- R8: Completed writes with `wrOp`=1 load `pwrDown` from `wrWord[3:0]`, where bit i belongs to channel i. Completed writes with `wrOp`=2 load `refEn` from `wrWord[0]`, and those with `wrOp`=3 load `hsMode` from `wrWord[0]`. A clear edge does not change `pwrDown` or `refEn`.
- R9: A low pulse on `ldacN` that lasts a single clock cycle is still seen as an update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| porMid | input | 1 | Reset code select: 1 = midscale, 0 = zero |
| ldacN | input | 1 | Asynchronous active-low update pin |
| clrN | input | 1 | Asynchronous active-low clear pin, falling-edge sensitive |
| wrStrobe | input | 1 | Captures a write (operation, channel, word) |
| wrOp | input | 2 | Write operation: 0 code, 1 power-down, 2 reference, 3 speed |
| chanSel | input | 2 | Target channel for a code write |
| wrWord | input | 16 | Write data word, code left-justified |
| wrDone | input | 1 | End-of-write event; commits the captured write |
| dacCode | output | 4*CODE_W | Output-stage codes, channel 0 in the low bits |
| newData | output | 4 | Per-channel pending-update flags |
| pwrDown | output | 4 | Per-channel power-down flags |
| refEn | output | 1 | Internal reference enable |
| hsMode | output | 1 | High-speed interface flag |
| clearMode | output | 1 | Clear condition active |

## Verification
Code writes are applied in three update settings: with the update pin idle and then pulsed for one cycle, with the pin held low, and with the clear pin held low. These settings separate a buffered load from a direct load from a blocked one. A second update pulse with no new data shows that untouched channels keep their codes. A clear edge placed between a strobe and its end-of-write event shows that a write is aborted rather than only delayed. Resets with both settings of the reset select, run at a 12-bit code width, show that midscale comes from the MSB of the parameterised code.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_PWRDN = 2'd1,
    OP_REF   = 2'd2,
    OP_SPEED = 2'd3
  } bank_op_e;

  typedef struct packed {
    logic clearAll;  // zero every stage, drop pending flags
    logic loadEn;    // commit a code to one input stage
    logic autoUpd;   // committed code also goes to the output stage
    logic xferAll;   // copy pending input stages to output stages
  } bank_strb_t;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,
  output logic lvlLow,
  output logic fallEdge
);
  // stage 0/1 synchronize, stage 2 holds the previous synced value
  logic [2:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= 3'b111;
    else       shReg <= {shReg[1:0], pinN};
  end

  assign lvlLow   = !shReg[1];
  assign fallEdge = shReg[2] & !shReg[1];
endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int NUM_CH = 4,
  parameter int WORD_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [1:0]        wrOp,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [WORD_W-1:0] wrWord,
  input  logic              wrDone,
  input  logic              ldacLow,
  input  logic              ldacFall,
  input  logic              clrLow,
  input  logic              clrFall,
  output bank_strb_t        strb,
  output logic [CH_W-1:0]   loadCh,
  output logic [CODE_W-1:0] loadCode,
  output logic [NUM_CH-1:0] pwrDown,
  output logic              refEn,
  output logic              hsMode,
  output logic              clearMode
);
  logic              pendValid;
  bank_op_e          pendOp;
  logic [CH_W-1:0]   pendCh;
  logic [WORD_W-1:0] pendWord;
  logic              commit;

  // a clear edge in the same cycle as wrDone wins and discards the write
  assign commit = wrDone & pendValid & !clrFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendOp    <= OP_LOAD;
      pendCh    <= '0;
      pendWord  <= '0;
    end else if (clrFall) begin
      pendValid <= 1'b0;
    end else if (wrStrobe) begin
      pendValid <= 1'b1;
      pendOp    <= bank_op_e'(wrOp);
      pendCh    <= chanSel;
      pendWord  <= wrWord;
    end else if (wrDone) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrDown   <= '0;
      refEn     <= 1'b0;
      hsMode    <= 1'b0;
      clearMode <= 1'b0;
    end else if (clrFall) begin
      hsMode    <= 1'b0;
      clearMode <= 1'b1;
    end else if (commit) begin
      clearMode <= 1'b0;
      case (pendOp)
        OP_PWRDN: pwrDown <= pendWord[NUM_CH-1:0];
        OP_REF:   refEn   <= pendWord[0];
        OP_SPEED: hsMode  <= pendWord[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    strb.clearAll = clrFall;
    strb.loadEn   = commit && (pendOp == OP_LOAD);
    strb.autoUpd  = ldacLow && !clrLow;
    strb.xferAll  = ldacFall && !clrLow && !clearMode;
  end

  assign loadCh   = pendCh;
  assign loadCode = pendWord[WORD_W-1 -: CODE_W];
endmodule

// File: rtl/dac_bank_dp.sv
module dac_bank_dp
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int NUM_CH = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     porMid,
  input  bank_strb_t               strb,
  input  logic [CH_W-1:0]          loadCh,
  input  logic [CODE_W-1:0]        loadCode,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        newData
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CODE_W-1:0] inReg;
    logic [CODE_W-1:0] outReg;
    logic              pendBit;
    logic              hit;

    assign hit = strb.loadEn && (loadCh == CH_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg   <= porMid ? MID_CODE : '0;
        outReg  <= porMid ? MID_CODE : '0;
        pendBit <= 1'b0;
      end else if (strb.clearAll) begin
        inReg   <= '0;
        outReg  <= '0;
        pendBit <= 1'b0;
      end else if (hit) begin
        inReg <= loadCode;
        if (strb.autoUpd) begin
          outReg  <= loadCode;
          pendBit <= 1'b0;
        end else begin
          pendBit <= 1'b1;
        end
      end else if (strb.xferAll && pendBit) begin
        outReg  <= inReg;
        pendBit <= 1'b0;
      end
    end

    assign dacCode[i*CODE_W +: CODE_W] = outReg;
    assign newData[i]                  = pendBit;
  end
endmodule

// File: rtl/dac_quad_bank.sv
module dac_quad_bank
  import dac_bank_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int NUM_CH = 4,
  parameter int WORD_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     porMid,
  input  logic                     ldacN,
  input  logic                     clrN,
  input  logic                     wrStrobe,
  input  logic [1:0]               wrOp,
  input  logic [CH_W-1:0]          chanSel,
  input  logic [WORD_W-1:0]        wrWord,
  input  logic                     wrDone,
  output logic [NUM_CH*CODE_W-1:0] dacCode,
  output logic [NUM_CH-1:0]        newData,
  output logic [NUM_CH-1:0]        pwrDown,
  output logic                     refEn,
  output logic                     hsMode,
  output logic                     clearMode
);
  logic              ldacLow, ldacFall, clrLow, clrFall;
  bank_strb_t        strb;
  logic [CH_W-1:0]   loadCh;
  logic [CODE_W-1:0] loadCode;

  dac_pin_sync u_ldacSync (
    .clk(clk), .rstN(rstN), .pinN(ldacN), .lvlLow(ldacLow), .fallEdge(ldacFall)
  );

  dac_pin_sync u_clrSync (
    .clk(clk), .rstN(rstN), .pinN(clrN), .lvlLow(clrLow), .fallEdge(clrFall)
  );

  dac_bank_ctrl #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrOp(wrOp), .chanSel(chanSel),
    .wrWord(wrWord), .wrDone(wrDone), .ldacLow(ldacLow), .ldacFall(ldacFall),
    .clrLow(clrLow), .clrFall(clrFall), .strb(strb), .loadCh(loadCh),
    .loadCode(loadCode), .pwrDown(pwrDown), .refEn(refEn), .hsMode(hsMode),
    .clearMode(clearMode)
  );

  dac_bank_dp #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .porMid(porMid), .strb(strb), .loadCh(loadCh),
    .loadCode(loadCode), .dacCode(dacCode), .newData(newData)
  );
endmodule

// File: rtl/dac_quad_bank_chk.sv
module dac_quad_bank_chk #(
  parameter int CODE_W = 16,
  parameter int NUM_CH = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH*CODE_W-1:0] dacCode,
  input logic [NUM_CH-1:0]        newData,
  input logic                     hsMode,
  input logic                     clearMode
);
  // entering the clear condition comes with all codes and pending flags zero
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearMode) |-> (dacCode == '0) && (newData == '0));

  // a clear edge always drops the high-speed flag
  assert_speed_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clearMode) |-> !hsMode);

  // while the clear condition persists no output code moves
  assert_clear_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clearMode && $past(clearMode)) |-> $stable(dacCode));

  // a buffered load leaves channel 0 output code alone
  assert_buffered_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(newData[0]) |-> $stable(dacCode[CODE_W-1:0]));

  // one completed write raises at most one pending flag
  assert_single_pend_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(newData & ~$past(newData)));
endmodule

bind dac_quad_bank dac_quad_bank_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .dacCode(dacCode), .newData(newData),
  .hsMode(hsMode), .clearMode(clearMode)
);

// File: tb/sim_dac_quad_bank.sv
module sim_dac_quad_bank;
  localparam int CW = 12;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, porMid = 1'b1, ldacN = 1'b1, clrN = 1'b1;
  logic wrStrobe = 1'b0, wrDone = 1'b0;
  logic [1:0] wrOp = 2'd0, chanSel = 2'd0;
  logic [15:0] wrWord = '0;
  logic [NC*CW-1:0] dacCode;
  logic [NC-1:0] newData, pwrDown;
  logic refEn, hsMode, clearMode;

  always #10 clk = ~clk;

  dac_quad_bank #(.CODE_W(CW), .NUM_CH(NC)) u0 (
    .clk(clk), .rstN(rstN), .porMid(porMid), .ldacN(ldacN), .clrN(clrN),
    .wrStrobe(wrStrobe), .wrOp(wrOp), .chanSel(chanSel), .wrWord(wrWord),
    .wrDone(wrDone), .dacCode(dacCode), .newData(newData), .pwrDown(pwrDown),
    .refEn(refEn), .hsMode(hsMode), .clearMode(clearMode)
  );

  typedef struct {
    logic [NC*CW-1:0] dac;
    logic [NC-1:0] nd;
    logic [NC-1:0] pd;
    logic ref_;
    logic hs;
    logic clm;
    string tag;
  } snap_t;

  snap_t scoreQ[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [CW-1:0] mIn[NC], mDac[NC];
  logic [NC-1:0] mNd, mPd;
  logic mRef, mHs, mClm, ldacHeld, clrHeld, pendStrobe;
  logic [1:0] pOp, pCh;
  logic [15:0] pWord;

  task automatic modelReset(input logic mid);
    for (int i = 0; i < NC; i++) begin
      mIn[i] = mid ? {1'b1, {(CW-1){1'b0}}} : '0;
      mDac[i] = mIn[i];
    end
    mNd = '0; mPd = '0; mRef = 0; mHs = 0; mClm = 0; pendStrobe = 0;
  endtask

  task automatic expectNow(input string tag);
    snap_t s;
    for (int i = 0; i < NC; i++) s.dac[i*CW +: CW] = mDac[i];
    s.nd = mNd; s.pd = mPd; s.ref_ = mRef; s.hs = mHs; s.clm = mClm; s.tag = tag;
    scoreQ.push_back(s);
    @(negedge clk);
  endtask

  // monitor: compare queued expectations with the ports
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      snap_t s;
      s = scoreQ.pop_front();
      checks++;
      if (dacCode !== s.dac || newData !== s.nd || pwrDown !== s.pd ||
          refEn !== s.ref_ || hsMode !== s.hs || clearMode !== s.clm) begin
        errors++;
        $display("FAIL %s: got dac=%h nd=%b pd=%b ref=%b hs=%b clm=%b exp dac=%h nd=%b pd=%b ref=%b hs=%b clm=%b",
                 s.tag, dacCode, newData, pwrDown, refEn, hsMode, clearMode,
                 s.dac, s.nd, s.pd, s.ref_, s.hs, s.clm);
      end
    end
  end

  task automatic strobeOnly(input logic [1:0] op, input logic [1:0] ch, input logic [15:0] w);
    @(negedge clk);
    wrStrobe = 1; wrOp = op; chanSel = ch; wrWord = w;
    @(negedge clk);
    wrStrobe = 0;
    pendStrobe = 1; pOp = op; pCh = ch; pWord = w;
  endtask

  task automatic doneOnly();
    repeat (2) @(negedge clk);
    wrDone = 1;
    @(negedge clk);
    wrDone = 0;
    if (pendStrobe) begin
      mClm = 0;
      case (pOp)
        2'd0: begin
          mIn[pCh] = pWord[15 -: CW];
          if (ldacHeld && !clrHeld) begin mDac[pCh] = pWord[15 -: CW]; mNd[pCh] = 0; end
          else mNd[pCh] = 1;
        end
        2'd1: mPd = pWord[NC-1:0];
        2'd2: mRef = pWord[0];
        default: mHs = pWord[0];
      endcase
    end
    pendStrobe = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic writeOp(input logic [1:0] op, input logic [1:0] ch, input logic [15:0] w);
    strobeOnly(op, ch, w);
    doneOnly();
  endtask

  task automatic modelLdacEdge();
    if (!clrHeld && !mClm)
      for (int i = 0; i < NC; i++)
        if (mNd[i]) begin mDac[i] = mIn[i]; mNd[i] = 0; end
  endtask

  task automatic ldacPulse();
    @(negedge clk); ldacN = 0;
    @(negedge clk); ldacN = 1;
    modelLdacEdge();
    repeat (5) @(negedge clk);
  endtask

  task automatic clrFallNow(input bit hold);
    @(negedge clk); clrN = 0; clrHeld = 1;
    if (!hold) begin @(negedge clk); clrN = 1; clrHeld = 0; end
    for (int i = 0; i < NC; i++) begin mIn[i] = '0; mDac[i] = '0; end
    mNd = '0; mClm = 1; mHs = 0; pendStrobe = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish exp finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ldacHeld = 0; clrHeld = 0;
    modelReset(1'b1);
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    expectNow("R1 reset to midscale");

    writeOp(2'd0, 2'd0, 16'h1230);
    expectNow("R2 buffered load ch0");
    writeOp(2'd0, 2'd2, 16'hABC0);
    expectNow("R2 buffered load ch2");
    ldacPulse();
    expectNow("R3 R9 one-cycle update pulse");
    ldacPulse();
    expectNow("R3 pulse without new data");

    @(negedge clk); ldacN = 0; ldacHeld = 1;
    modelLdacEdge();
    repeat (5) @(negedge clk);
    writeOp(2'd0, 2'd3, 16'hFFF0);
    expectNow("R4 held-low direct load ch3");
    @(negedge clk); ldacN = 1; ldacHeld = 0;
    repeat (4) @(negedge clk);

    writeOp(2'd1, 2'd0, 16'h000A);
    writeOp(2'd2, 2'd0, 16'h0001);
    writeOp(2'd3, 2'd0, 16'h0001);
    expectNow("R8 power-down, reference, speed flags");

    clrFallNow(1'b1);
    expectNow("R5 R7 clear edge zeroes, speed dropped, flags kept");
    writeOp(2'd0, 2'd1, 16'h4440);
    expectNow("R6 write under clear ends clear condition");
    ldacPulse();
    expectNow("R6 update ignored while clear low");
    @(negedge clk); clrN = 1; clrHeld = 0;
    repeat (4) @(negedge clk);
    ldacPulse();
    expectNow("R3 update after clear released");

    strobeOnly(2'd0, 2'd2, 16'h7770);
    clrFallNow(1'b0);
    doneOnly();
    expectNow("R7 aborted write leaves no trace");
    ldacPulse();
    expectNow("R6 update in clear condition");
    writeOp(2'd0, 2'd2, 16'h7770);
    ldacPulse();
    expectNow("R6 clear condition ended by write");

    @(negedge clk); rstN = 0; porMid = 0;
    modelReset(1'b0);
    repeat (2) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    expectNow("R1 reset to zero-scale");

    wait (scoreQ.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule